// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block generates the internal reset for a small processor core and decides when the core may enter power-down. It takes three reset sources: a low level on the external reset pin, a software reset request and a watchdog reset request. Any of them starts an internal reset that lasts a fixed number of clock cycles after the last active source. The reset-indication output falls with every reset and stays low until the core signals the end of its initialisation.

A mode bit can make the external reset pin bidirectional. With the bit set, the block turns on an open-drain pull-low on the pin for the whole internal reset, whichever source started it. The block does not count its own pull-low, or the settling that follows it, as a new external reset. The non-maskable interrupt pin is synchronised. Each falling edge on it raises a one-cycle trap request. A power-down request puts the block into power-down only while the synchronised interrupt level is low, and only a hardware reset brings it out again.

Top module: `rst_pd_seq`

## Requirements
- R1: A low level on the external reset pin starts a reset only when it is seen low at the synchroniser output on QUAL_CYC (default 2) consecutive cycles. With the defaults, a pin held low across two sampling edges raises `core_rst_o` after the fourth clock edge. A pin low across only one sampling edge has no effect.
- R2: `core_rst_o` is high out of power-on reset. It stays high for exactly SEQ_LEN cycles (default 16) after the last clock edge at which any reset source was active.
- R3: A one-cycle software or watchdog request raises `core_rst_o` at the next clock edge. A new request during an active reset restarts the SEQ_LEN count.
- R4: `rst_ind_no` is 0 during reset and stays 0 after reset ends. It goes to 1 one edge after an `einit_i` pulse given outside reset. An `einit_i` pulse given during reset has no effect.
- R5: A `bidir_set_i` pulse given outside reset sets the bidirectional mode bit. While the bit is 1, `rst_pin_pull_o` is 1 exactly when `core_rst_o` is 1, for any reset source. Power-on reset clears the bit, and so does the end of a hardware reset. Software and watchdog resets leave it unchanged.
- R6: The block's own pull-low on the reset pin, and the pin's return through the synchroniser after the pull-low is released, never start or extend a reset.
- R7: A high-to-low change on `nmi_pin_i` makes `nmi_trap_o` high for exactly one cycle, three clock edges after the change. A low-to-high change makes no trap.
- R8: A `pd_req_i` pulse sets `pd_o` at the next edge only if the synchronised NMI level is low and no reset is active. If NMI is high, `pd_o` stays 0.
- R9: While `pd_o` is 1, NMI falling edges, software requests and watchdog requests are ignored. Only an accepted hardware reset clears `pd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_ni | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| rst_pin_ni | input | 1 | Level on the external reset pin, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset request pulse |
| wdt_rst_i | input | 1 | Watchdog reset request pulse |
| einit_i | input | 1 | End-of-initialisation strobe |
| pd_req_i | input | 1 | Power-down request strobe |
| bidir_set_i | input | 1 | Strobe that sets the bidirectional reset mode bit |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, asynchronous |
| core_rst_o | output | 1 | Internal reset, active high |
| rst_ind_no | output | 1 | Reset indication, active low |
| rst_pin_pull_o | output | 1 | Open-drain pull-low enable for the reset pin |
| nmi_trap_o | output | 1 | One-cycle NMI trap request |
| pd_o | output | 1 | Power-down state |

## Verification
A wrong sequence count shows as `core_rst_o` falling one or more cycles early or late. The bench checks that output on every cycle of each sequence, so the error is seen at the first wrong edge. A wrong pin mask or a wrong qualifier count shows as a reset that starts again within a few cycles of the pull-low release, or as a reset taken or missed on a short pin pulse. A corrupted mode bit, NMI history or power-down flag shows on the next reset as a wrong `rst_pin_pull_o`, or on the next NMI or request as a missing or extra trap, or a wrong `pd_o`.

// File: rtl/rps_pkg.sv
package rps_pkg;
  // Reset sources active in one cycle
  typedef struct packed {
    logic hw;
    logic sw;
    logic wdt;
  } rps_src_t;

  localparam int unsigned RPS_SYNC_STAGES = 2;
endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d_i;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rps_pin_qual.sv
module rps_pin_qual #(
  parameter int unsigned QUAL_CYC = 2,
  parameter int unsigned MASK_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic pull_i,
  output logic hw_src_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam int unsigned MW = $clog2(MASK_LEN + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);
  localparam logic [QW-1:0] QHIT = QW'(QUAL_CYC - 1);
  localparam logic [MW-1:0] MLOAD = MW'(MASK_LEN);

  logic [QW-1:0] low_q, low_d;
  logic [MW-1:0] msk_q, msk_d;
  logic          ign;

  assign ign = pull_i || (msk_q != '0);

  always_comb begin
    low_d = low_q;
    if (ign || pin_s_i)    low_d = '0;
    else if (low_q != QMAX) low_d = low_q + 1'b1;
    msk_d = msk_q;
    if (pull_i)             msk_d = MLOAD;
    else if (msk_q != '0)   msk_d = msk_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
      msk_q <= '0;
    end else begin
      low_q <= low_d;
      msk_q <= msk_d;
    end
  end

  assign hw_src_o = !ign && !pin_s_i && (low_q >= QHIT);

  generate
    if (QUAL_CYC >= 2) begin : g_chk
      // R1
      pin_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_src_o |-> $past(!pin_s_i));
      // R6
      own_pull_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pull_i) |-> !hw_src_o);
    end
  endgenerate
endmodule

// File: rtl/rps_seq.sv
module rps_seq
  import rps_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rps_src_t src_i,
  input  logic     einit_i,
  input  logic     bidir_set_i,
  output logic     busy_o,
  output logic     ind_n_o,
  output logic     pull_o
);
  localparam int unsigned CW = $clog2(SEQ_LEN + 1);
  localparam logic [CW-1:0] CLOAD = CW'(SEQ_LEN);
  localparam logic [CW-1:0] CLAST = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ind_q, ind_d;
  logic          hws_q, hws_d;
  logic          bdr_q, bdr_d;
  logic          any_src, busy, ending;

  assign any_src = src_i.hw | src_i.sw | src_i.wdt;
  assign busy    = (cnt_q != '0);
  assign ending  = (cnt_q == CLAST) && !any_src;

  always_comb begin
    cnt_d = cnt_q;
    if (any_src)   cnt_d = CLOAD;
    else if (busy) cnt_d = cnt_q - 1'b1;

    ind_d = ind_q;
    if (any_src || busy) ind_d = 1'b0;
    else if (einit_i)    ind_d = 1'b1;

    hws_d = hws_q;
    if (src_i.hw)    hws_d = 1'b1;
    else if (ending) hws_d = 1'b0;

    bdr_d = bdr_q;
    if (ending && hws_q)                      bdr_d = 1'b0;
    else if (!busy && !any_src && bidir_set_i) bdr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CLOAD;
      ind_q <= 1'b0;
      hws_q <= 1'b1;
      bdr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ind_q <= ind_d;
      hws_q <= hws_d;
      bdr_q <= bdr_d;
    end
  end

  assign busy_o  = busy;
  assign ind_n_o = ind_q;
  assign pull_o  = bdr_q && busy;

  // R2
  seq_countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_src && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3
  seq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i.sw || src_i.wdt) |=> (cnt_q == CLOAD));
  // R4
  ind_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_q |-> !busy);
  // R5
  bdr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bdr_q && busy && !hws_q && !src_i.hw) |=> bdr_q);
endmodule

// File: rtl/rps_nmi_pd.sv
module rps_nmi_pd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_s_i,
  input  logic pd_req_i,
  input  logic hw_src_i,
  input  logic busy_i,
  output logic trap_o,
  output logic pd_o
);
  logic nmi_d_q;
  logic trap_q, trap_d;
  logic pd_q, pd_d;
  logic fall;

  assign fall = nmi_d_q && !nmi_s_i;

  always_comb begin
    trap_d = fall && !pd_q;
    pd_d   = pd_q;
    if (hw_src_i)                               pd_d = 1'b0;
    else if (pd_req_i && !nmi_s_i && !busy_i)   pd_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d_q <= 1'b1;
      trap_q  <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      nmi_d_q <= nmi_s_i;
      trap_q  <= trap_d;
      pd_q    <= pd_d;
    end
  end

  assign trap_o = trap_q;
  assign pd_o   = pd_q;

  // R7
  trap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |=> !trap_q);
  // R8
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(pd_req_i && !nmi_s_i));
  // R9
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && !hw_src_i) |=> pd_q);
endmodule

// File: rtl/rst_pd_seq.sv
module rst_pd_seq
  import rps_pkg::*;
#(
  parameter int unsigned SEQ_LEN  = 16,
  parameter int unsigned QUAL_CYC = 2
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic rst_pin_ni,
  input  logic sw_rst_i,
  input  logic wdt_rst_i,
  input  logic einit_i,
  input  logic pd_req_i,
  input  logic bidir_set_i,
  input  logic nmi_pin_i,
  output logic core_rst_o,
  output logic rst_ind_no,
  output logic rst_pin_pull_o,
  output logic nmi_trap_o,
  output logic pd_o
);
  localparam int unsigned MASK_LEN = RPS_SYNC_STAGES + 1;

  logic [1:0] por_q;
  logic       rst_n;
  logic       pin_s, nmi_s, hw_src, busy, pull, pd;
  rps_src_t   src;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) por_q <= 2'b00;
    else         por_q <= {por_q[0], 1'b1};
  end
  assign rst_n = por_q[1];

  rps_sync #(.STAGES(RPS_SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(rst_pin_ni), .q_o(pin_s));

  rps_sync #(.STAGES(RPS_SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(nmi_pin_i), .q_o(nmi_s));

  rps_pin_qual #(.QUAL_CYC(QUAL_CYC), .MASK_LEN(MASK_LEN)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_n), .pin_s_i(pin_s), .pull_i(pull),
    .hw_src_o(hw_src));

  assign src.hw  = hw_src;
  assign src.sw  = sw_rst_i  && !pd;
  assign src.wdt = wdt_rst_i && !pd;

  rps_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .src_i(src), .einit_i(einit_i),
    .bidir_set_i(bidir_set_i), .busy_o(busy), .ind_n_o(rst_ind_no),
    .pull_o(pull));

  rps_nmi_pd u_nmi_pd (
    .clk_i(clk_i), .rst_ni(rst_n), .nmi_s_i(nmi_s), .pd_req_i(pd_req_i),
    .hw_src_i(hw_src), .busy_i(busy), .trap_o(nmi_trap_o), .pd_o(pd));

  assign core_rst_o     = busy;
  assign rst_pin_pull_o = pull;
  assign pd_o           = pd;

  // R5
  pull_follows_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_pin_pull_o |-> core_rst_o);
endmodule

// File: tb/sim_rst_pd_seq.sv
module sim_rst_pd_seq;
  localparam int CLK_P = 10;
  localparam int SEQ   = 16;

  logic clk = 1'b0;
  logic por_n, ext_n, sw, wdt, einit, pdreq, bset, nmi;
  logic core_rst, ind_n, pull, trap, pd;
  logic pin;
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign pin = ext_n & ~pull;

  rst_pd_seq u0 (
    .clk_i(clk), .por_ni(por_n), .rst_pin_ni(pin), .sw_rst_i(sw),
    .wdt_rst_i(wdt), .einit_i(einit), .pd_req_i(pdreq), .bidir_set_i(bset),
    .nmi_pin_i(nmi), .core_rst_o(core_rst), .rst_ind_no(ind_n),
    .rst_pin_pull_o(pull), .nmi_trap_o(trap), .pd_o(pd));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic pulse_sw();
    sw = 1'b1; step(1); sw = 1'b0;
  endtask

  task automatic pulse_einit();
    einit = 1'b1; step(1); einit = 1'b0;
  endtask

  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    por_n = 0; ext_n = 1; sw = 0; wdt = 0; einit = 0; pdreq = 0;
    bset = 0; nmi = 1;
    step(3);
    chk(core_rst, 1'b1, "R2 reset state core_rst");
    chk(ind_n, 1'b0, "R4 reset state ind");
    chk(pull, 1'b0, "R5 reset state pull");
    chk(pd, 1'b0, "R8 reset state pd");
    chk(trap, 1'b0, "R7 reset state trap");
    por_n = 1;
    step(30);
    chk(core_rst, 1'b0, "R2 por sequence ends");
    chk(ind_n, 1'b0, "R4 ind held after reset");
    pulse_einit();
    chk(ind_n, 1'b1, "R4 einit releases ind");

    // R2 R3 software reset: exact length, einit inside reset ignored
    pulse_sw();
    for (int k = 1; k <= SEQ + 4; k++) begin
      chk(core_rst, logic'(k <= SEQ), "R2 sw sequence length");
      if (k == 8) einit = 1'b1;
      if (k == 9) einit = 1'b0;
      step(1);
    end
    chk(ind_n, 1'b0, "R4 einit during reset ignored");
    pulse_einit();
    chk(ind_n, 1'b1, "R4 einit after reset");

    // R3 watchdog then software restart
    wdt = 1'b1; step(1); wdt = 1'b0;
    chk(core_rst, 1'b1, "R3 wdt starts reset");
    chk(ind_n, 1'b0, "R4 ind falls on wdt");
    step(5);
    pulse_sw();
    for (int k = 1; k <= SEQ + 3; k++) begin
      chk(core_rst, logic'(k <= SEQ), "R3 restart length");
      step(1);
    end
    pulse_einit();

    // R1 one-cycle pin pulse rejected
    ext_n = 1'b0; step(1); ext_n = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      chk(core_rst, 1'b0, "R1 short pulse rejected");
      step(1);
    end
    chk(ind_n, 1'b1, "R1 short pulse leaves ind");

    // R1 R2 two-cycle pin pulse accepted, edge k after drive
    ext_n = 1'b0; step(2); ext_n = 1'b1;
    for (int k = 3; k <= 22; k++) begin
      step(1);
      chk(core_rst, logic'(k >= 4 && k <= 3 + SEQ), "R1 qualified pin reset");
    end
    chk(ind_n, 1'b0, "R4 ind after hw reset");
    pulse_einit();

    // R5 R6 bidirectional mode with software reset
    bset = 1'b1; step(1); bset = 1'b0;
    step(1);
    pulse_sw();
    for (int k = 1; k <= SEQ + 8; k++) begin
      chk(pull, logic'(k <= SEQ), "R5 pull during sw reset");
      chk(core_rst, logic'(k <= SEQ), "R6 own pull not a new reset");
      step(1);
    end
    wdt = 1'b1; step(1); wdt = 1'b0;
    chk(pull, 1'b1, "R5 bit kept after sw reset, pull on wdt");
    step(SEQ + 6);
    chk(core_rst, 1'b0, "R6 no retrigger after wdt pull");

    // R5 hardware reset in bidir mode pulls, then clears bit
    ext_n = 1'b0; step(2); ext_n = 1'b1;
    step(4);
    chk(pull, 1'b1, "R5 pull during hw reset");
    step(SEQ + 6);
    chk(core_rst, 1'b0, "R6 hw bidir sequence ends");
    pulse_sw();
    chk(core_rst, 1'b1, "R3 sw after hw");
    chk(pull, 1'b0, "R5 bit cleared by hw reset");
    step(SEQ + 2);
    pulse_einit();

    // R7 NMI edges
    nmi = 1'b0; step(2);
    chk(trap, 1'b0, "R7 trap not early");
    step(1);
    chk(trap, 1'b1, "R7 trap on falling edge");
    step(1);
    chk(trap, 1'b0, "R7 trap one cycle");
    nmi = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      chk(trap, 1'b0, "R7 no trap on rising edge");
      step(1);
    end

    // R8 power-down refused with NMI high
    pdreq = 1'b1; step(1); pdreq = 1'b0;
    chk(pd, 1'b0, "R8 pd refused nmi high");
    nmi = 1'b0; step(5);
    pdreq = 1'b1; step(1); pdreq = 1'b0;
    chk(pd, 1'b1, "R8 pd entered nmi low");

    // R9 in power-down: NMI edge, sw, wdt ignored
    nmi = 1'b1; step(4); nmi = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      chk(trap, 1'b0, "R9 nmi ignored in pd");
      step(1);
    end
    pulse_sw();
    wdt = 1'b1; step(1); wdt = 1'b0;
    step(1);
    chk(core_rst, 1'b0, "R9 sw wdt ignored in pd");
    chk(pd, 1'b1, "R9 pd held");
    ext_n = 1'b0; step(2); ext_n = 1'b1;
    step(2);
    chk(core_rst, 1'b1, "R9 hw reset in pd");
    chk(pd, 1'b0, "R9 hw reset leaves pd");
    step(SEQ + 4);
    chk(core_rst, 1'b0, "R2 final sequence ends");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule